// File: doc/BRIEF.md
# Operand Address Generation Unit

This unit decides where an instruction's operand comes from in a small microcontroller built in programmable logic. Each cycle it takes a mode code, the constant field of the instruction word and the value read from the register file. It then produces one of two results. The first is the operand value itself, for the implied, immediate and register modes. The second is a data-memory address, for the base, page and indirect modes. A flag output says which of the two results is valid.

The memory modes use an auxiliary address register that lives inside the unit. A separate load strobe writes it. Base mode adds the instruction constant to that register. Page mode places the register's top bits in front of the constant. Indirect mode uses the register as the whole address. A parameter sets whether the results pass through one output register or leave the unit combinationally. Instruction decode, the memories and the ALU sit outside the unit.

Top module: `oagu_top`

## Requirements
- R1: After reset, `operand_o`, `addr_o` and `is_addr_o` are all zero, and the auxiliary register holds zero.
- R2: Mode 0 (implied) drives `operand_o` = 0, `addr_o` = 0 and `is_addr_o` = 0. The consumer takes the operand from a location fixed by the operation.
- R3: Mode 1 (immediate) drives `operand_o` with `const_i` zero-extended to the data width, and drives `is_addr_o` = 0.
- R4: Mode 2 (register) drives `operand_o` with `rf_data_i` and drives `is_addr_o` = 0.
- R5: Mode 3 (base) drives `addr_o` = auxiliary register + zero-extended `const_i`, wrapping modulo 2^ADDR_W, and drives `is_addr_o` = 1.
- R6: Mode 4 (page) drives `addr_o` = {auxiliary register bits [ADDR_W-1 : ADDR_W-PAGE_W], `const_i`} and drives `is_addr_o` = 1.
- R7: Mode 5 (indirect) drives `addr_o` with the full auxiliary register value and drives `is_addr_o` = 1.
- R8: On a rising clock edge with `aux_load_i` high, the auxiliary register takes `aux_data_i`. With `aux_load_i` low it keeps its value. An operation presented in the same cycle as a load uses the old value.
- R9: Mode codes 6 and 7 drive `operand_o`, `addr_o` and `is_addr_o` all to zero.
- R10: With OUT_REG = 1 the results for inputs presented in one cycle appear after the next rising edge. With OUT_REG = 0 they appear in the same cycle.
- R11: Whenever `is_addr_o` is 1, `operand_o` is zero. Whenever `is_addr_o` is 0, `addr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operand source mode code |
| const_i | input | CONST_W | Constant field of the instruction word |
| rf_data_i | input | DATA_W | Value read from the register file |
| aux_load_i | input | 1 | Load strobe for the auxiliary address register |
| aux_data_i | input | ADDR_W | New auxiliary register value |
| operand_o | output | DATA_W | Selected operand value |
| addr_o | output | ADDR_W | Data-memory address |
| is_addr_o | output | 1 | High when `addr_o` is the valid result |

## Verification
The bench builds the unit with its default widths: a 16-bit address, an 8-bit constant, an 8-bit page field and 8-bit data. It also sets OUT_REG = 1, so every result lands one cycle after its inputs. With these values the base-mode sum carries out of the low byte and wraps past 0xFFFF. The page field is exactly the auxiliary register's upper byte. A load strobe that arrives together with a memory-mode operation shows whether the old register value is used. Random constants, register-file values and auxiliary contents are mixed with directed cases for the unused codes and for reset.

// File: rtl/oagu_pkg.sv
package oagu_pkg;
   localparam int MODE_W = 3;

   localparam logic [MODE_W-1:0] MODE_IMPL = 3'd0;
   localparam logic [MODE_W-1:0] MODE_IMM  = 3'd1;
   localparam logic [MODE_W-1:0] MODE_REG  = 3'd2;
   localparam logic [MODE_W-1:0] MODE_BASE = 3'd3;
   localparam logic [MODE_W-1:0] MODE_PAGE = 3'd4;
   localparam logic [MODE_W-1:0] MODE_IND  = 3'd5;

   function automatic logic mode_is_mem(input logic [MODE_W-1:0] m);
      return (m == MODE_BASE) || (m == MODE_PAGE) || (m == MODE_IND);
   endfunction
endpackage

// File: rtl/oagu_aux_reg.sv
module oagu_aux_reg #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o <= '0;
      else if (load_i) q_o <= data_i;
   end
endmodule

// File: rtl/oagu_addr_calc.sv
module oagu_addr_calc
   import oagu_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int CONST_W = 8,
   parameter int PAGE_W  = 8
) (
   input  logic [MODE_W-1:0]  mode_i,
   input  logic [ADDR_W-1:0]  aux_i,
   input  logic [CONST_W-1:0] const_i,
   output logic [ADDR_W-1:0]  addr_o,
   output logic               valid_o
);
   localparam int EXT_W = ADDR_W - CONST_W;

   logic [ADDR_W-1:0] const_ext;
   logic [ADDR_W-1:0] base_sum;
   logic [ADDR_W-1:0] page_addr;

   assign const_ext = {{EXT_W{1'b0}}, const_i};
   assign base_sum  = aux_i + const_ext;
   assign page_addr = {aux_i[ADDR_W-1 -: PAGE_W], const_i};

   always_comb begin
      addr_o  = '0;
      valid_o = 1'b0;
      case (mode_i)
         MODE_BASE: begin addr_o = base_sum;  valid_o = 1'b1; end
         MODE_PAGE: begin addr_o = page_addr; valid_o = 1'b1; end
         MODE_IND:  begin addr_o = aux_i;     valid_o = 1'b1; end
         default: ;
      endcase
   end
endmodule

// File: rtl/oagu_operand_sel.sv
module oagu_operand_sel
   import oagu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CONST_W = 8
) (
   input  logic [MODE_W-1:0]  mode_i,
   input  logic [CONST_W-1:0] const_i,
   input  logic [DATA_W-1:0]  rf_data_i,
   output logic [DATA_W-1:0]  operand_o
);
   logic [DATA_W-1:0] imm_ext;

   generate
      if (DATA_W == CONST_W) begin : g_imm_same
         assign imm_ext = const_i;
      end else begin : g_imm_zext
         assign imm_ext = {{(DATA_W-CONST_W){1'b0}}, const_i};
      end
   endgenerate

   always_comb begin
      case (mode_i)
         MODE_IMM: operand_o = imm_ext;
         MODE_REG: operand_o = rf_data_i;
         default:  operand_o = '0;
      endcase
   end
endmodule

// File: rtl/oagu_top.sv
module oagu_top
   import oagu_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int CONST_W = 8,
   parameter int PAGE_W  = 8,
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [2:0]         mode_i,
   input  logic [CONST_W-1:0] const_i,
   input  logic [DATA_W-1:0]  rf_data_i,
   input  logic               aux_load_i,
   input  logic [ADDR_W-1:0]  aux_data_i,
   output logic [DATA_W-1:0]  operand_o,
   output logic [ADDR_W-1:0]  addr_o,
   output logic               is_addr_o
);
   generate
      if (PAGE_W + CONST_W != ADDR_W) begin : g_bad_page
         $error("oagu_top: PAGE_W + CONST_W must equal ADDR_W");
      end
      if (CONST_W >= ADDR_W) begin : g_bad_const
         $error("oagu_top: CONST_W must be narrower than ADDR_W");
      end
      if (DATA_W < CONST_W) begin : g_bad_data
         $error("oagu_top: DATA_W must be at least CONST_W");
      end
   endgenerate

   logic [ADDR_W-1:0] aux_q;
   logic [ADDR_W-1:0] addr_c;
   logic              mem_c;
   logic [DATA_W-1:0] opnd_c;

   oagu_aux_reg #(.W(ADDR_W)) u_aux (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (aux_load_i),
      .data_i (aux_data_i),
      .q_o    (aux_q)
   );

   oagu_addr_calc #(.ADDR_W(ADDR_W), .CONST_W(CONST_W), .PAGE_W(PAGE_W)) u_addr (
      .mode_i  (mode_i),
      .aux_i   (aux_q),
      .const_i (const_i),
      .addr_o  (addr_c),
      .valid_o (mem_c)
   );

   oagu_operand_sel #(.DATA_W(DATA_W), .CONST_W(CONST_W)) u_opnd (
      .mode_i    (mode_i),
      .const_i   (const_i),
      .rf_data_i (rf_data_i),
      .operand_o (opnd_c)
   );

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               operand_o <= '0;
               addr_o    <= '0;
               is_addr_o <= 1'b0;
            end else begin
               operand_o <= opnd_c;
               addr_o    <= addr_c;
               is_addr_o <= mem_c;
            end
         end
      end else begin : g_out_comb
         assign operand_o = opnd_c;
         assign addr_o    = addr_c;
         assign is_addr_o = mem_c;
      end
   endgenerate
endmodule

// File: rtl/oagu_chk.sv
module oagu_chk
   import oagu_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int CONST_W = 8,
   parameter int PAGE_W  = 8,
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [2:0]         mode_i,
   input logic [CONST_W-1:0] const_i,
   input logic [DATA_W-1:0]  rf_data_i,
   input logic               aux_load_i,
   input logic [ADDR_W-1:0]  aux_data_i,
   input logic [ADDR_W-1:0]  aux_q,
   input logic [DATA_W-1:0]  operand_o,
   input logic [ADDR_W-1:0]  addr_o,
   input logic               is_addr_o
);
   logic               v;
   logic [2:0]         m_v;
   logic [CONST_W-1:0] c_v;
   logic [DATA_W-1:0]  r_v;
   logic [ADDR_W-1:0]  a_v;

   generate
      if (OUT_REG) begin : g_lag
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               v <= 1'b0; m_v <= '0; c_v <= '0; r_v <= '0; a_v <= '0;
            end else begin
               v <= 1'b1; m_v <= mode_i; c_v <= const_i; r_v <= rf_data_i; a_v <= aux_q;
            end
         end
      end else begin : g_now
         assign v   = 1'b1;
         assign m_v = mode_i;
         assign c_v = const_i;
         assign r_v = rf_data_i;
         assign a_v = aux_q;
      end
   endgenerate

   logic [ADDR_W-1:0] base_ref;
   assign base_ref = a_v + ADDR_W'(c_v);

   // R3
   imm_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v && m_v == MODE_IMM) |-> (operand_o == DATA_W'(c_v) && !is_addr_o));
   // R4
   reg_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v && m_v == MODE_REG) |-> (operand_o == r_v && !is_addr_o));
   // R5
   base_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v && m_v == MODE_BASE) |-> (addr_o == base_ref && is_addr_o));
   // R7
   ind_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v && m_v == MODE_IND) |-> (addr_o == a_v && is_addr_o));
   // R9
   unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v && m_v > MODE_IND) |-> (operand_o == '0 && addr_o == '0 && !is_addr_o));
   // R8
   aux_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      aux_load_i |=> (aux_q == $past(aux_data_i)));
   // R8
   aux_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !aux_load_i |=> $stable(aux_q));
   // R11
   split_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_addr_o ? (operand_o == '0) : (addr_o == '0));
endmodule

bind oagu_top oagu_chk #(
   .ADDR_W(ADDR_W), .CONST_W(CONST_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .mode_i     (mode_i),
   .const_i    (const_i),
   .rf_data_i  (rf_data_i),
   .aux_load_i (aux_load_i),
   .aux_data_i (aux_data_i),
   .aux_q      (aux_q),
   .operand_o  (operand_o),
   .addr_o     (addr_o),
   .is_addr_o  (is_addr_o)
);

// File: tb/oagu_top_tb_top.sv
module oagu_top_tb_top;
   localparam int ADDR_W  = 16;
   localparam int CONST_W = 8;
   localparam int PAGE_W  = 8;
   localparam int DATA_W  = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [2:0]         mode = 3'd7;
   logic [CONST_W-1:0] cst = '0;
   logic [DATA_W-1:0]  rf = '0;
   logic               ld = 1'b0;
   logic [ADDR_W-1:0]  ad = '0;
   logic [DATA_W-1:0]  operand;
   logic [ADDR_W-1:0]  addr;
   logic               is_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [ADDR_W-1:0] aux_m = '0;
   logic [DATA_W-1:0] q_op[$];
   logic [ADDR_W-1:0] q_ad[$];
   logic              q_fl[$];
   string             q_rq[$];

   always #10 clk = ~clk;

   oagu_top #(.ADDR_W(ADDR_W), .CONST_W(CONST_W), .PAGE_W(PAGE_W),
              .DATA_W(DATA_W), .OUT_REG(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .const_i(cst), .rf_data_i(rf),
      .aux_load_i(ld), .aux_data_i(ad), .operand_o(operand), .addr_o(addr),
      .is_addr_o(is_addr)
   );

   task automatic compare(string rq, logic [DATA_W-1:0] eo, logic [ADDR_W-1:0] ea, logic ef);
      checks++;
      if (operand !== eo || addr !== ea || is_addr !== ef) begin
         errors++;
         $display("FAIL %s: got op=%h addr=%h flag=%b, expected op=%h addr=%h flag=%b",
                  rq, operand, addr, is_addr, eo, ea, ef);
      end
   endtask

   // Driver: presents one operation and queues its expected result.
   task automatic drive(logic [2:0] m, logic [CONST_W-1:0] c, logic [DATA_W-1:0] r,
                        logic l, logic [ADDR_W-1:0] d);
      logic [DATA_W-1:0] eo;
      logic [ADDR_W-1:0] ea;
      logic ef;
      string rq;
      @(negedge clk);
      mode = m; cst = c; rf = r; ld = l; ad = d;
      eo = '0; ea = '0; ef = 1'b0;
      case (m)
         3'd0: rq = "R2 R11";
         3'd1: begin eo = DATA_W'(c); rq = "R3 R10 R11"; end
         3'd2: begin eo = r; rq = "R4 R10"; end
         3'd3: begin ea = aux_m + ADDR_W'(c); ef = 1'b1; rq = "R5 R8 R11"; end
         3'd4: begin ea = {aux_m[ADDR_W-1 -: PAGE_W], c}; ef = 1'b1; rq = "R6 R8"; end
         3'd5: begin ea = aux_m; ef = 1'b1; rq = "R7 R8"; end
         default: rq = "R9";
      endcase
      q_op.push_back(eo); q_ad.push_back(ea); q_fl.push_back(ef); q_rq.push_back(rq);
      if (l) aux_m = d;
   endtask

   // Monitor: compares each result one edge after its inputs.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q_op.size() > 0)
            compare(q_rq.pop_front(), q_op.pop_front(), q_ad.pop_front(), q_fl.pop_front());
      end
   end

   initial begin
      #4000000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state at the outputs
      compare("R1", '0, '0, 1'b0);
      rst_n = 1'b1;
      // R1: auxiliary register starts at zero
      drive(3'd5, 8'h00, 8'h00, 1'b0, '0);
      drive(3'd1, 8'hA5, 8'h3C, 1'b0, '0);
      drive(3'd2, 8'h11, 8'hC3, 1'b0, '0);
      drive(3'd0, 8'hFF, 8'hFF, 1'b0, '0);
      // R8: load together with an indirect op uses the old value
      drive(3'd5, 8'h00, 8'h00, 1'b1, 16'hFFF0);
      drive(3'd5, 8'h00, 8'h00, 1'b0, 16'h1234);
      // R5: base sum wraps past the top of the address space
      drive(3'd3, 8'h20, 8'h00, 1'b0, '0);
      drive(3'd4, 8'h7E, 8'h00, 1'b0, '0);
      // R9: unused codes
      drive(3'd6, 8'h55, 8'hAA, 1'b0, '0);
      drive(3'd7, 8'hAA, 8'h55, 1'b0, '0);
      // R8: hold while load is low
      drive(3'd5, 8'h00, 8'h00, 1'b0, 16'h0BAD);
      for (int i = 0; i < 400; i++) begin
         drive(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom),
               1'($urandom_range(0, 2) == 0), 16'($urandom));
      end
      @(negedge clk);
      mode = 3'd7; ld = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule